// File: doc/BRIEF.md
# Windowed Threshold Interrupt Controller with Persistence

This block sits beside a light-sensing ADC and judges each finished conversion on one channel against a programmed window bounded by a low and a high threshold. A persistence filter decides which conversions qualify. The filter can pass every conversion, pass any single out-of-window value, or require an uninterrupted run of out-of-window values that lasts a set number of time-base ticks. A qualified event raises an active-low interrupt. The block models that interrupt as a drive-low enable for an open-drain pad.

A two-bit mode selects how the interrupt behaves. The interrupt can be off. In level mode it holds until software issues a clear. In alert mode it holds until an alert-response unit reports that it answered successfully. A fourth mode forces an interrupt at the moment it is entered and then behaves like alert mode. When stop-on-interrupt is set, an asserted interrupt also halts integration. Integration restarts only after the ADC enable has been dropped, the interrupt has been cleared, and the enable has been raised again.

Top module: `thr_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, irq_drive_low, integ_stop and alert_pend are all 0.
- R2: A conversion is out of window exactly when its value is strictly below thr_lo or strictly above thr_hi. A value equal to either threshold is in window. With persist_sel=001 in level mode (irq_mode=01), an out-of-window conversion sets irq_drive_low on the cycle after conv_valid, and an in-window conversion does not.
- R3: With persist_sel=000, every conversion raises the interrupt, whatever its value.
- R4: With persist_sel=010 (or 011), a run starts at an out-of-window conversion with its tick count at 0. The count grows by one for each tick cycle after that conversion. A later out-of-window conversion in the same run raises the interrupt only if the count has reached 10 (or 100). An in-window conversion ends the run.
- R5: persist_sel values 100 to 111 never raise the interrupt from a conversion.
- R6: With irq_mode=00, irq_drive_low is 0 from the next cycle on, and conversions raise nothing.
- R7: In level mode the interrupt stays asserted until a sw_clear pulse, which drops it on the next cycle. alert_ack has no effect, and alert_pend stays 0.
- R8: In alert mode (irq_mode=10), alert_pend follows the interrupt. sw_clear has no effect, and an alert_ack pulse drops both signals on the next cycle.
- R9: A change of irq_mode to 11 raises the interrupt and alert_pend on the next cycle without any conversion. While irq_mode stays 11, the block behaves as alert mode and does not force again.
- R10: When a qualifying event and a clear arrive in the same cycle, the interrupt stays asserted.
- R11: With stop_en=1, integ_stop rises one cycle after irq_drive_low rises. With stop_en=0, integ_stop stays 0.
- R12: Once halted, integ_stop stays 1 until adc_en has been 0 while the interrupt is clear, and adc_en is then 1. It falls on the cycle after adc_en is sampled high. Raising adc_en again before the clear keeps it halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_data | input | DW | Conversion result |
| thr_lo | input | DW | Low edge of the window (inclusive) |
| thr_hi | input | DW | High edge of the window (inclusive) |
| irq_mode | input | 2 | 00 off, 01 level, 10 alert, 11 force then alert |
| persist_sel | input | 3 | Persistence code |
| stop_en | input | 1 | Halt integration while an interrupt is asserted |
| tick | input | 1 | Time-base tick, one cycle per 10 ms |
| sw_clear | input | 1 | Software clear strobe (level mode) |
| adc_en | input | 1 | ADC enable as written by software |
| alert_ack | input | 1 | Alert-response unit answered successfully |
| irq_drive_low | output | 1 | Pull the interrupt pad low |
| integ_stop | output | 1 | Request to halt integration |
| alert_pend | output | 1 | Alert pending, for the alert-response unit |

## Verification
The hardest states to reach are the boundaries of the tick-counted persistence runs and the out-of-order steps of the restart sequence. To reach the run boundaries, the bench starts a run with one out-of-window conversion and issues exactly 9 or 10 ticks (99 or 100 for the long setting) before the next conversion. It also breaks a run with an in-window value after the count has passed the limit. For the restart sequence, the bench halts integration and then tries to resume by raising the enable before the clear. It then performs the correct disable, clear and enable order, so that it sees both the held-stop case and the release cycle.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;
  typedef enum logic [1:0] {
    IM_OFF   = 2'b00,
    IM_LEVEL = 2'b01,
    IM_ALERT = 2'b10,
    IM_FORCE = 2'b11
  } irq_mode_e;

  typedef enum logic [2:0] {
    PS_EVERY = 3'b000,
    PS_ANY   = 3'b001,
    PS_SHORT = 3'b010,
    PS_LONG  = 3'b011
  } persist_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_HALT,
    ST_WAIT_CLR,
    ST_WAIT_EN
  } stop_state_e;
endpackage

// File: rtl/thr_window_cmp.sv
module thr_window_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          outside
);
  logic below, above;
  always_comb begin
    below   = value < lo;
    above   = value > hi;
    outside = below | above;
  end
endmodule

// File: rtl/thr_persist_filt.sv
module thr_persist_filt
  import thr_irq_pkg::*;
#(
  parameter int TICKS_SHORT = 10,
  parameter int TICKS_LONG  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       conv_valid,
  input  logic       outside,
  input  logic [2:0] persist_sel,
  input  logic       tick,
  output logic       fire
);
  localparam int CW = $clog2(TICKS_LONG + 1);
  localparam logic [CW-1:0] NEED_S  = CW'(TICKS_SHORT);
  localparam logic [CW-1:0] NEED_L  = CW'(TICKS_LONG);
  localparam logic [CW-1:0] CNT_MAX = CW'(TICKS_LONG);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (conv_valid && !outside) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (conv_valid && !armed_q) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    fire = 1'b0;
    if (conv_valid) begin
      unique case (persist_sel)
        PS_EVERY: fire = 1'b1;
        PS_ANY:   fire = outside;
        PS_SHORT: fire = outside && armed_q && (cnt_q >= NEED_S);
        PS_LONG:  fire = outside && armed_q && (cnt_q >= NEED_L);
        default:  fire = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/thr_irq_core.sv
module thr_irq_core
  import thr_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] irq_mode,
  input  logic       fire,
  input  logic       sw_clear,
  input  logic       alert_ack,
  output logic       irq_q,
  output logic       alert_q
);
  irq_mode_e mode, prev_mode_q;
  logic      force_now, irq_d;

  always_comb begin
    mode      = irq_mode_e'(irq_mode);
    force_now = (mode == IM_FORCE) && (prev_mode_q != IM_FORCE);
    if (mode == IM_OFF)
      irq_d = 1'b0;
    else if (fire || force_now)
      irq_d = 1'b1;
    else if (mode == IM_LEVEL && sw_clear)
      irq_d = 1'b0;
    else if (mode[1] && alert_ack)
      irq_d = 1'b0;
    else
      irq_d = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mode_q <= IM_OFF;
      irq_q       <= 1'b0;
      alert_q     <= 1'b0;
    end else begin
      prev_mode_q <= mode;
      irq_q       <= irq_d;
      alert_q     <= irq_d && mode[1];
    end
  end
endmodule

// File: rtl/thr_stop_seq.sv
module thr_stop_seq
  import thr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic stop_en,
  input  logic adc_en,
  output logic stop_q
);
  stop_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:      if (stop_en && irq) st_d = ST_HALT;
      ST_HALT:     if (!adc_en) st_d = ST_WAIT_CLR;
      ST_WAIT_CLR: if (!irq) st_d = ST_WAIT_EN;
                   else if (adc_en) st_d = ST_HALT;
      ST_WAIT_EN:  if (adc_en) st_d = ST_RUN;
      default:     st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stop_q <= (st_d != ST_RUN);
    end
  end
endmodule

// File: rtl/thr_irq_ctrl.sv
module thr_irq_ctrl #(
  parameter int DW          = 16,
  parameter int TICKS_SHORT = 10,
  parameter int TICKS_LONG  = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic [1:0]    irq_mode,
  input  logic [2:0]    persist_sel,
  input  logic          stop_en,
  input  logic          tick,
  input  logic          sw_clear,
  input  logic          adc_en,
  input  logic          alert_ack,
  output logic          irq_drive_low,
  output logic          integ_stop,
  output logic          alert_pend
);
  logic outside, fire, irq_q, alert_q, stop_q;

  thr_window_cmp #(.DW(DW)) u_cmp (
    .value   (conv_data),
    .lo      (thr_lo),
    .hi      (thr_hi),
    .outside (outside)
  );

  thr_persist_filt #(.TICKS_SHORT(TICKS_SHORT), .TICKS_LONG(TICKS_LONG)) u_filt (
    .clk         (clk),
    .rst         (rst),
    .conv_valid  (conv_valid),
    .outside     (outside),
    .persist_sel (persist_sel),
    .tick        (tick),
    .fire        (fire)
  );

  thr_irq_core u_core (
    .clk       (clk),
    .rst       (rst),
    .irq_mode  (irq_mode),
    .fire      (fire),
    .sw_clear  (sw_clear),
    .alert_ack (alert_ack),
    .irq_q     (irq_q),
    .alert_q   (alert_q)
  );

  thr_stop_seq u_stop (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq_q),
    .stop_en (stop_en),
    .adc_en  (adc_en),
    .stop_q  (stop_q)
  );

  assign irq_drive_low = irq_q;
  assign alert_pend    = alert_q;
  assign integ_stop    = stop_q;
endmodule

// File: rtl/thr_irq_ctrl_chk.sv
module thr_irq_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_valid,
  input logic [DW-1:0] conv_data,
  input logic [DW-1:0] thr_lo,
  input logic [DW-1:0] thr_hi,
  input logic [1:0]    irq_mode,
  input logic [2:0]    persist_sel,
  input logic          stop_en,
  input logic          sw_clear,
  input logic          adc_en,
  input logic          alert_ack,
  input logic          irq_drive_low,
  input logic          integ_stop,
  input logic          alert_pend
);
  assert_out_of_window_fires_R2: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && irq_mode != 2'b00 && persist_sel == 3'b001 &&
     (conv_data < thr_lo || conv_data > thr_hi)) |=> irq_drive_low);

  assert_off_mode_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_mode == 2'b00) |=> !irq_drive_low);

  assert_level_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_drive_low && irq_mode == 2'b01 && !sw_clear) |=> irq_drive_low);

  assert_alert_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_drive_low && irq_mode[1] && !alert_ack) |=> irq_drive_low);

  assert_pend_implies_irq_R8: assert property (@(posedge clk) disable iff (rst)
    alert_pend |-> (irq_drive_low && $past(irq_mode[1])));

  assert_stop_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(integ_stop) |-> $past(irq_drive_low && stop_en));

  assert_resume_needs_enable_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(integ_stop) |-> $past(adc_en));
endmodule

bind thr_irq_ctrl thr_irq_ctrl_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .conv_valid    (conv_valid),
  .conv_data     (conv_data),
  .thr_lo        (thr_lo),
  .thr_hi        (thr_hi),
  .irq_mode      (irq_mode),
  .persist_sel   (persist_sel),
  .stop_en       (stop_en),
  .sw_clear      (sw_clear),
  .adc_en        (adc_en),
  .alert_ack     (alert_ack),
  .irq_drive_low (irq_drive_low),
  .integ_stop    (integ_stop),
  .alert_pend    (alert_pend)
);

// File: tb/tb_thr_irq_ctrl.sv
module tb_thr_irq_ctrl;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, conv_valid, stop_en, tick, sw_clear, adc_en, alert_ack;
  logic [DW-1:0] conv_data, thr_lo, thr_hi;
  logic [1:0]    irq_mode;
  logic [2:0]    persist_sel;
  logic          irq_drive_low, integ_stop, alert_pend;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  thr_irq_ctrl #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .irq_mode(irq_mode), .persist_sel(persist_sel),
    .stop_en(stop_en), .tick(tick), .sw_clear(sw_clear), .adc_en(adc_en),
    .alert_ack(alert_ack), .irq_drive_low(irq_drive_low), .integ_stop(integ_stop),
    .alert_pend(alert_pend)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic conv(input logic [DW-1:0] d);
    conv_valid = 1'b1; conv_data = d;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic clear_pulse();
    sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic ack_pulse();
    alert_ack = 1'b1; @(negedge clk); alert_ack = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] los [3];
    logic [DW-1:0] his [3];
    rst = 1'b1; conv_valid = 0; conv_data = '0; thr_lo = '0; thr_hi = '0;
    irq_mode = 2'b00; persist_sel = 3'b001; stop_en = 0; tick = 0;
    sw_clear = 0; adc_en = 1; alert_ack = 0;
    los = '{16'd100, 16'd50, 16'd200};
    his = '{16'd200, 16'd50, 16'd100};
    cyc(3);
    chk(irq_drive_low, 1'b0, "R1 irq");
    chk(integ_stop, 1'b0, "R1 stop");
    chk(alert_pend, 1'b0, "R1 pend");
    rst = 1'b0;
    cyc(1);
    chk(irq_drive_low, 1'b0, "R1 after release");

    // R2 window sweep, level mode, single-value persistence
    irq_mode = 2'b01; persist_sel = 3'b001; cyc(1);
    for (int p = 0; p < 3; p++) begin
      logic [DW-1:0] cand [8];
      thr_lo = los[p]; thr_hi = his[p];
      cand = '{los[p] - 1'b1, los[p], los[p] + 1'b1, his[p] - 1'b1,
               his[p], his[p] + 1'b1, '0, '1};
      for (int k = 0; k < 8; k++) begin
        logic exp;
        exp = (cand[k] < los[p]) || (cand[k] > his[p]);
        conv(cand[k]);
        chk(irq_drive_low, exp, "R2 window");
        chk(integ_stop, 1'b0, "R11 no stop when disabled");
        clear_pulse();
        chk(irq_drive_low, 1'b0, "R7 clear");
      end
    end
    thr_lo = 16'd100; thr_hi = 16'd200;

    // R7 level: ack ignored, no pending flag
    conv(16'd300);
    chk(alert_pend, 1'b0, "R7 pend stays 0");
    ack_pulse();
    chk(irq_drive_low, 1'b1, "R7 ack ignored");
    clear_pulse();
    chk(irq_drive_low, 1'b0, "R7 sw clear");

    // R3 every conversion
    persist_sel = 3'b000;
    conv(16'd150);
    chk(irq_drive_low, 1'b1, "R3 in-window fires");
    clear_pulse();

    // R5 reserved codes
    for (int ps = 4; ps < 8; ps++) begin
      persist_sel = 3'(ps);
      conv(16'd300);
      chk(irq_drive_low, 1'b0, "R5 reserved out");
      conv(16'd150);
      chk(irq_drive_low, 1'b0, "R5 reserved in");
    end

    // R4 short persistence (10 ticks)
    persist_sel = 3'b010;
    conv(16'd150); conv(16'd300);
    chk(irq_drive_low, 1'b0, "R4 run start");
    ticks(9); conv(16'd300);
    chk(irq_drive_low, 1'b0, "R4 9 ticks");
    ticks(1); conv(16'd300);
    chk(irq_drive_low, 1'b1, "R4 10 ticks");
    clear_pulse();
    conv(16'd300);
    chk(irq_drive_low, 1'b1, "R4 run continues");
    clear_pulse();
    conv(16'd150); conv(16'd300); ticks(12); conv(16'd150); conv(16'd300); conv(16'd300);
    chk(irq_drive_low, 1'b0, "R4 in-window resets run");
    // R4 long persistence (100 ticks)
    persist_sel = 3'b011;
    conv(16'd150); conv(16'd300); ticks(99); conv(16'd300);
    chk(irq_drive_low, 1'b0, "R4 99 ticks");
    ticks(1); conv(16'd300);
    chk(irq_drive_low, 1'b1, "R4 100 ticks");
    clear_pulse();

    // R6 off mode
    persist_sel = 3'b001;
    conv(16'd300);
    chk(irq_drive_low, 1'b1, "R6 setup");
    irq_mode = 2'b00; cyc(1);
    chk(irq_drive_low, 1'b0, "R6 off clears");
    conv(16'd300);
    chk(irq_drive_low, 1'b0, "R6 off no fire");

    // R8 alert mode
    irq_mode = 2'b10;
    conv(16'd10);
    chk(irq_drive_low, 1'b1, "R8 irq");
    chk(alert_pend, 1'b1, "R8 pend");
    clear_pulse();
    chk(irq_drive_low, 1'b1, "R8 sw clear ignored");
    ack_pulse();
    chk(irq_drive_low, 1'b0, "R8 ack clears irq");
    chk(alert_pend, 1'b0, "R8 ack clears pend");

    // R9 force mode
    irq_mode = 2'b11; cyc(1);
    chk(irq_drive_low, 1'b1, "R9 force irq");
    chk(alert_pend, 1'b1, "R9 force pend");
    ack_pulse(); cyc(3);
    chk(irq_drive_low, 1'b0, "R9 no re-force");
    conv(16'd300);
    chk(alert_pend, 1'b1, "R9 acts as alert");
    ack_pulse();
    irq_mode = 2'b10; cyc(1); irq_mode = 2'b11; cyc(1);
    chk(irq_drive_low, 1'b1, "R9 re-entry forces");
    ack_pulse();

    // R10 set wins over clear
    irq_mode = 2'b01;
    conv(16'd300);
    conv_valid = 1'b1; conv_data = 16'd300; sw_clear = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0; sw_clear = 1'b0;
    chk(irq_drive_low, 1'b1, "R10 level set wins");
    clear_pulse();
    irq_mode = 2'b10; cyc(1);
    conv_valid = 1'b1; conv_data = 16'd300; alert_ack = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0; alert_ack = 1'b0;
    chk(irq_drive_low, 1'b1, "R10 alert set wins");
    ack_pulse();

    // R11 stop-on-interrupt
    irq_mode = 2'b01; stop_en = 1'b1;
    conv(16'd300);
    chk(irq_drive_low, 1'b1, "R11 irq");
    chk(integ_stop, 1'b0, "R11 stop lags one cycle");
    cyc(1);
    chk(integ_stop, 1'b1, "R11 stop raised");

    // R12 restart sequence: clear then disable/enable
    clear_pulse(); cyc(3);
    chk(integ_stop, 1'b1, "R12 clear alone keeps stop");
    adc_en = 1'b0; cyc(3); adc_en = 1'b1; cyc(2);
    chk(integ_stop, 1'b0, "R12 resumed");
    // wrong order: re-enable before clear
    conv(16'd300); cyc(1);
    chk(integ_stop, 1'b1, "R12 halted again");
    adc_en = 1'b0; cyc(2); adc_en = 1'b1; cyc(3);
    chk(integ_stop, 1'b1, "R12 enable before clear held");
    adc_en = 1'b0; cyc(2); clear_pulse(); cyc(2);
    chk(integ_stop, 1'b1, "R12 still stopped while disabled");
    adc_en = 1'b1; @(negedge clk);
    chk(integ_stop, 1'b0, "R12 release on enable");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule